// File: doc/BRIEF.md
# Serial Audio Transmit Serializer

This block plays PCM audio out over a three-wire serial frame: a bit clock, a left/right clock and one serial data line for each channel pair. It drives both clocks itself as the frame master. Each channel pair has a four-entry FIFO. A request/acknowledge port fills these FIFOs from memory: the block raises `dma_req` and names the pair it wants, and the memory side answers with `dma_ack` and one 32-bit word. A frame is 64 bit clocks long: a 32-bit left slot (`lrclk` low) followed by a 32-bit right slot (`lrclk` high). Each sample starts one bit clock after the `lrclk` edge and is sent MSB first.

Four states drive the block. In IDLE the FIFOs are held empty and every output is low. The IDLE→NULL transition happens when `run` is high and `clk_gate` is low. In NULL the clocks toggle and the frames carry zeros. NULL→STREAM happens only at a frame boundary, and only when pair 0 holds a complete frame of data, so a null pair that is already being sent always finishes. NULL/STREAM→STOP happens when `run` drops or `clk_gate` rises in the middle of a frame. STOP→IDLE happens at the next frame boundary. NULL/STREAM→IDLE happens directly when the stop condition is already present at a boundary.

In STREAM, every frame boundary loads each active pair from its FIFO. A pair whose FIFO cannot supply a whole frame sends a null pair instead, and the sticky `underrun` flag is set.

Top module: `sat_serializer`

## Requirements
- R1: While the block is in IDLE, `bclk`, `lrclk`, every `sdata` bit and `dma_req` are all 0. The block is in IDLE after reset, while `clk_gate`=1, and while `run`=0 once any stop has completed.
- R2: While running, one `bclk` period lasts 2×BCLK_HALF system clocks and one frame lasts 64 `bclk` periods. `lrclk` is 0 for the first 32 bits (left slot) and 1 for the last 32 bits (right slot). `lrclk` changes only on a falling `bclk`, and a frame lasts at least 22 system clocks.
- R3: Within a slot, bit 0 carries padding. Bits 1..31 carry slot word bits 31..1, MSB first, so bit 31 of the word goes out one `bclk` after the `lrclk` edge. With `fmt16`=1, a single FIFO entry feeds the whole frame: the left slot word is {entry[31:16],16'h0} and the right slot word is {entry[15:0],16'h0}. With `fmt16`=0, two entries feed one frame: the left slot word is {older[23:0],8'h0} and the right slot word is {newer[23:0],8'h0}. `sdata` changes only on a falling `bclk`.
- R4: After a start, frames carry all-zero data until pair 0 holds enough entries for one frame. The switch to data happens at a frame boundary, so the zero slots before the first data form whole left/right pairs, and the first nonzero slot is a left slot.
- R5: `dma_req` is high in NULL and STREAM whenever an active pair's FIFO is not full. `dma_pair` names the lowest-numbered such pair, and a cycle with both `dma_req` and `dma_ack` high writes `dma_data` into that pair's FIFO. If every acknowledge is prompt, exactly 4×(`pairs_m1`+1) transfers take place before the first frame boundary, and `dma_req` then stays low.
- R6: The number of active pairs is `pairs_m1`+1. `dma_pair` never names an inactive pair, and the `sdata` bit of an inactive pair stays 0.
- R7: In STREAM, an active pair whose FIFO holds too few entries at a frame boundary sends a zero left/right pair for that frame. This sets `underrun`, which holds until the next start. No FIFO data is dropped, so the data order is unchanged.
- R8: When `run` drops, the clocks stop at the next frame boundary, so a run always contains a whole number of 64-bit frames. The FIFOs are emptied: after a restart, the first data sent is the first word transferred after that restart.
- R9: If the memory side always acknowledges promptly, `underrun` stays 0 for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable |
| clk_gate | input | 1 | Clock gate; 1 holds the block inactive |
| fmt16 | input | 1 | 1: 16-bit samples, one left/right pair per word; 0: 24-bit samples, one per word |
| pairs_m1 | input | PW | Number of active channel pairs minus one |
| dma_req | output | 1 | Request for one data word |
| dma_pair | output | PW | Channel pair the request is for |
| dma_ack | input | 1 | Acknowledge; `dma_data` is valid |
| dma_data | input | 32 | Sample word |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right clock, low for the left slot |
| sdata | output | NUM_PAIRS | Serial data, one bit per channel pair |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench tries all four combinations of sample format and active-pair count with a memory model that acknowledges promptly, and decodes every slot back into a word. A swapped half, a shifted bit or a pair that has been left idle shows up as a word mismatch or as stray activity on the inactive line. Stalled runs hold back acknowledges for several frames. These separate a correct null-pair insertion, which keeps data in order, from dropped or repeated data. Stopping between configurations and starting again with a fresh word counter shows whether the FIFOs were really emptied and whether each run stopped on a frame boundary.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NULL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_STOP   = 2'd3
    } sat_state_e;

    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int WORD_W     = 32;

    // Left slot word built from the FIFO head.
    function automatic logic [31:0] left_slot(input logic f16, input logic [31:0] h0);
        return f16 ? {h0[31:16], 16'h0} : {h0[23:0], 8'h0};
    endfunction

    // Right slot word: low half of the head, or the second entry in wide mode.
    function automatic logic [31:0] right_slot(input logic f16, input logic [31:0] h0,
                                               input logic [31:0] h1);
        return f16 ? {h0[15:0], 16'h0} : {h1[23:0], 8'h0};
    endfunction

endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       pop_n,
    output logic [WIDTH-1:0] head0,
    output logic [WIDTH-1:0] head1,
    output logic [CW-1:0]    level,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + CW'(wr_en) - CW'(pop_n);
        end
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];
    assign full  = (level == CW'(DEPTH));
endmodule

// File: rtl/sat_req_arb.sv
module sat_req_arb #(
    parameter  int NUM_PAIRS = 2,
    localparam int PW        = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 enable,
    input  logic [PW-1:0]        pairs_m1,
    input  logic [NUM_PAIRS-1:0] full_v,
    output logic                 req,
    output logic [PW-1:0]        pair
);
    // Highest index first so the lowest non-full active pair wins.
    always_comb begin
        req  = 1'b0;
        pair = '0;
        for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
            if (enable && (PW'(p) <= pairs_m1) && !full_v[p]) begin
                req  = 1'b1;
                pair = PW'(p);
            end
        end
    end
endmodule

// File: rtl/sat_frame_fsm.sv
module sat_frame_fsm
    import sat_pkg::*;
#(
    parameter int BCLK_HALF = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       ready0,
    output logic       running,
    output logic       feeding,
    output logic       idle,
    output logic       bclk,
    output logic       lrclk,
    output logic [4:0] slot_pos,
    output logic       start,
    output logic       load_data,
    output logic       load_null
);
    localparam int PHW  = (2 * BCLK_HALF > 2) ? $clog2(2 * BCLK_HALF) : 1;
    localparam int FPW  = $clog2(FRAME_BITS);

    sat_state_e     state, nxt;
    logic [PHW-1:0] ph;
    logic [FPW-1:0] fpos;
    logic           tick, boundary;

    assign tick     = (ph == PHW'(2 * BCLK_HALF - 1));
    assign boundary = (state != ST_IDLE) && tick && (fpos == FPW'(FRAME_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Bit-phase and frame-position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            fpos <= '0;
        end else if (state == ST_IDLE) begin
            ph   <= '0;
            fpos <= '0;
        end else if (tick) begin
            ph   <= '0;
            fpos <= fpos + FPW'(1);
        end else begin
            ph   <= ph + PHW'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_NULL;
            ST_NULL:   if (!go) nxt = boundary ? ST_IDLE : ST_STOP;
                       else if (boundary && ready0) nxt = ST_STREAM;
            ST_STREAM: if (!go) nxt = boundary ? ST_IDLE : ST_STOP;
            ST_STOP:   if (boundary) nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        idle      = (state == ST_IDLE);
        running   = !idle;
        feeding   = (state == ST_NULL) || (state == ST_STREAM);
        bclk      = running && (int'(ph) >= BCLK_HALF);
        lrclk     = running && fpos[FPW-1];
        slot_pos  = fpos[4:0];
        start     = idle && go;
        load_data = boundary && (nxt == ST_STREAM);
        load_null = start || (boundary && (nxt == ST_NULL));
    end
endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
    import sat_pkg::*;
#(
    parameter  int NUM_PAIRS  = 2,
    parameter  int FIFO_DEPTH = 4,
    parameter  int BCLK_HALF  = 1,
    localparam int PW         = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clk_gate,
    input  logic                 fmt16,
    input  logic [PW-1:0]        pairs_m1,
    output logic                 dma_req,
    output logic [PW-1:0]        dma_pair,
    input  logic                 dma_ack,
    input  logic [WORD_W-1:0]    dma_data,
    output logic                 bclk,
    output logic                 lrclk,
    output logic [NUM_PAIRS-1:0] sdata,
    output logic                 underrun
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic                 running, feeding, idle, start, load_data, load_null;
    logic [4:0]           slot_pos, bidx;
    logic [NUM_PAIRS-1:0] ok_v, full_v, short_v;

    sat_frame_fsm #(.BCLK_HALF(BCLK_HALF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(run && !clk_gate), .ready0(ok_v[0]),
        .running(running), .feeding(feeding), .idle(idle), .bclk(bclk),
        .lrclk(lrclk), .slot_pos(slot_pos), .start(start),
        .load_data(load_data), .load_null(load_null)
    );

    sat_req_arb #(.NUM_PAIRS(NUM_PAIRS)) u_arb (
        .enable(feeding), .pairs_m1(pairs_m1), .full_v(full_v),
        .req(dma_req), .pair(dma_pair)
    );

    // Slot bit p (1..31) carries word bit 32-p.
    assign bidx = ~(slot_pos - 5'd1);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [WORD_W-1:0] h0, h1, lw, rw;
        logic [CW-1:0]     lvl;
        logic              act, wr;
        logic [1:0]        pop;

        assign act        = (PW'(p) <= pairs_m1);
        assign ok_v[p]    = fmt16 ? (lvl != '0) : (lvl >= CW'(2));
        assign wr         = dma_ack && dma_req && (dma_pair == PW'(p));
        assign pop        = (load_data && act && ok_v[p]) ? (fmt16 ? 2'd1 : 2'd2) : 2'd0;
        assign short_v[p] = load_data && act && !ok_v[p];

        sat_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .flush(idle), .wr_en(wr), .wr_data(dma_data),
            .pop_n(pop), .head0(h0), .head1(h1), .level(lvl), .full(full_v[p])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lw <= '0;
                rw <= '0;
            end else if (load_null || short_v[p]) begin
                lw <= '0;
                rw <= '0;
            end else if (load_data) begin
                lw <= left_slot(fmt16, h0);
                rw <= right_slot(fmt16, h0, h1);
            end
        end

        assign sdata[p] = running && act && (slot_pos != 5'd0) &&
                          (lrclk ? rw[bidx] : lw[bidx]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        underrun <= 1'b0;
        else if (start)    underrun <= 1'b0;
        else if (|short_v) underrun <= 1'b1;
    end
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
    parameter  int NUM_PAIRS = 2,
    localparam int PW        = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 running,
    input logic                 bclk,
    input logic                 lrclk,
    input logic [NUM_PAIRS-1:0] sdata,
    input logic                 dma_req,
    input logic [PW-1:0]        dma_pair,
    input logic [PW-1:0]        pairs_m1,
    input logic                 underrun
);
    logic [NUM_PAIRS-1:0] act_mask;
    always_comb begin
        for (int p = 0; p < NUM_PAIRS; p++) act_mask[p] = (PW'(p) <= pairs_m1);
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!bclk && !lrclk && (sdata == '0) && !dma_req));

    p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> $fell(bclk));

    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    p_req_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_pair <= pairs_m1));

    p_inactive_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata & ~act_mask) == '0);

    p_underrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && running) |=> underrun);
endmodule

bind sat_serializer sat_checker #(.NUM_PAIRS(NUM_PAIRS)) u_sat_checker (
    .clk(clk), .rst_n(rst_n), .running(running), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .dma_req(dma_req), .dma_pair(dma_pair), .pairs_m1(pairs_m1),
    .underrun(underrun)
);

// File: tb/tb_sat_serializer.sv
`timescale 1ns/1ps
module tb_sat_serializer;
    localparam int NP        = 2;
    localparam int HALF      = 1;
    localparam int FRAME_CYC = 64 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n, run, clk_gate, fmt16, pairs_m1;
    logic        dma_req, dma_pair, dma_ack, bclk, lrclk, underrun;
    logic [31:0] dma_data;
    logic [NP-1:0] sdata;

    always #5 clk = ~clk;

    sat_serializer #(.NUM_PAIRS(NP), .FIFO_DEPTH(4), .BCLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_gate(clk_gate), .fmt16(fmt16),
        .pairs_m1(pairs_m1), .dma_req(dma_req), .dma_pair(dma_pair),
        .dma_ack(dma_ack), .dma_data(dma_data), .bclk(bclk), .lrclk(lrclk),
        .sdata(sdata), .underrun(underrun)
    );

    int checks = 0, errors = 0;
    logic bench_clr = 1'b1, stall = 1'b0;

    function automatic logic [31:0] gen(input int p, input int n);
        return {4'(p + 1), 4'h5, 8'(n + 1), 4'(p + 1), 4'hA, 8'(n + 1)};
    endfunction

    function automatic logic [31:0] exp_slot(input int p, input int k, input logic f16);
        logic [31:0] w;
        if (f16) begin
            w = gen(p, k / 2);
            return (k % 2 == 0) ? {w[31:16], 16'h0} : {w[15:0], 16'h0};
        end
        w = gen(p, k);
        return {w[23:0], 8'h0};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Memory-side model: answers each request one cycle later unless stalled.
    int tx_cnt [NP];
    int ack_cnt;
    always @(negedge clk) begin
        if (bench_clr) begin
            dma_ack = 1'b0; dma_data = '0; ack_cnt = 0;
            for (int p = 0; p < NP; p++) tx_cnt[p] = 0;
        end else if (!stall && dma_req && !dma_ack) begin
            dma_ack  = 1'b1;
            dma_data = gen(int'(dma_pair), tx_cnt[int'(dma_pair)]);
            tx_cnt[int'(dma_pair)]++;
            ack_cnt++;
        end else begin
            dma_ack = 1'b0;
        end
    end

    // Serial receiver: rebuilds slot words from the wires.
    logic [31:0] sr [NP];
    int rxn [NP], bad [NP], nul_pre [NP], nul_post [NP];
    bit started [NP], first_right [NP];
    logic [31:0] bad_act, bad_exp;
    int rises, inact_high, bper, fper, nfr;
    longint cyc = 0, last_b, last_f;
    logic prev_bclk, prev_lr;

    task automatic take_slot(input int p, input logic lr);
        logic [31:0] e;
        if (sr[p] == 32'h0) begin
            if (started[p]) nul_post[p]++;
            else            nul_pre[p]++;
        end else begin
            if (!started[p]) begin
                started[p] = 1'b1;
                first_right[p] = lr;
            end
            e = exp_slot(p, rxn[p], fmt16);
            if (sr[p] != e) begin
                if (bad[p] == 0) begin bad_act = sr[p]; bad_exp = e; end
                bad[p]++;
            end
            rxn[p]++;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (bench_clr) begin
            rises = 0; inact_high = 0; bper = 0; fper = 0; nfr = 0;
            last_b = 0; last_f = 0; prev_bclk = 1'b0; prev_lr = 1'b0;
            for (int p = 0; p < NP; p++) begin
                sr[p] = '0; rxn[p] = 0; bad[p] = 0; nul_pre[p] = 0; nul_post[p] = 0;
                started[p] = 1'b0; first_right[p] = 1'b0;
            end
        end else begin
            for (int p = 0; p < NP; p++)
                if (p > int'(pairs_m1) && sdata[p]) inact_high++;
            if (bclk && !prev_bclk) begin
                rises++;
                bper = int'(cyc - last_b);
                last_b = cyc;
                for (int p = 0; p < NP; p++) sr[p] = {sr[p][30:0], sdata[p]};
                if (lrclk != prev_lr) begin
                    for (int p = 0; p < NP; p++)
                        if (p <= int'(pairs_m1)) take_slot(p, prev_lr);
                    if (lrclk) begin
                        fper = int'(cyc - last_f);
                        last_f = cyc;
                        nfr++;
                    end
                    prev_lr = lrclk;
                end
            end
            prev_bclk = bclk;
        end
    end

    task automatic clear_bench();
        bench_clr = 1'b1;
        repeat (2) @(negedge clk);
        bench_clr = 1'b0;
    endtask

    task automatic run_cfg(input logic f16, input logic pm1, input bit stall_en);
        int np;
        np = int'(pm1) + 1;
        fmt16 = f16; pairs_m1 = pm1;
        clear_bench();
        run = 1'b1;
        repeat (100) @(negedge clk);
        // R5: all active FIFOs filled, then requests stop
        chk(ack_cnt == 4 * np, "R5", "transfers before first boundary", ack_cnt, 4 * np);
        chk(dma_req == 1'b0, "R5", "request after fill", dma_req, 0);
        if (stall_en) begin
            repeat (3 * FRAME_CYC) @(negedge clk);
            stall = 1'b1;
            repeat (8 * FRAME_CYC) @(negedge clk);
            stall = 1'b0;
            repeat (8 * FRAME_CYC) @(negedge clk);
        end else begin
            repeat (12 * FRAME_CYC) @(negedge clk);
        end
        run = 1'b0;
        repeat (300) @(negedge clk);
        // R2: clock periods and ratio
        chk(bper == 2 * HALF, "R2", "bclk period", bper, 2 * HALF);
        chk(nfr >= 2 && fper == FRAME_CYC, "R2", "frame period", fper, FRAME_CYC);
        chk(fper >= 22, "R2", "sysclk per frame at least 22", fper, 22);
        for (int p = 0; p < np; p++) begin
            // R4: null pairs first, first data in a left slot
            chk(started[p], "R4", "data reached output", started[p], 1);
            chk(!first_right[p], "R4", "first data slot is left", first_right[p], 0);
            chk(nul_pre[p] >= 2 && nul_pre[p] % 2 == 0, "R4", "whole null pairs before data",
                nul_pre[p], 2);
            // R3 and R8: decoded words match the transfers made since this start
            chk(bad[p] == 0, "R3", "slot word", bad_act, bad_exp);
            chk(rxn[p] >= 16, "R3", "data slots received", rxn[p], 16);
            if (stall_en)
                chk(nul_post[p] > 0 && nul_post[p] % 2 == 0, "R7", "null pairs on underrun",
                    nul_post[p], 2);
            else
                chk(nul_post[p] == 0, "R9", "no null slots after data", nul_post[p], 0);
        end
        // R6: inactive line quiet
        chk(inact_high == 0, "R6", "inactive sdata high samples", inact_high, 0);
        // R8: stop on frame boundary
        chk(rises % 64 == 0, "R8", "bit clocks per run mod 64", rises % 64, 0);
        // R1: quiet after stop
        chk(!bclk && !lrclk && sdata == '0 && !dma_req, "R1", "outputs after stop",
            {bclk, lrclk, sdata, dma_req}, 0);
        if (stall_en) chk(underrun == 1'b1, "R7", "underrun flag", underrun, 1);
        else          chk(underrun == 1'b0, "R9", "underrun flag", underrun, 0);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; clk_gate = 1'b0; fmt16 = 1'b1; pairs_m1 = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!bclk && !lrclk && sdata == '0 && !dma_req && !underrun, "R1", "reset outputs",
            {bclk, lrclk, sdata, dma_req, underrun}, 0);
        // R1: clock gate holds the block inactive even with run set
        clock_gate_test();
        run_cfg(1'b1, 1'b0, 1'b0);
        run_cfg(1'b1, 1'b1, 1'b0);
        run_cfg(1'b0, 1'b0, 1'b0);
        run_cfg(1'b0, 1'b1, 1'b0);
        run_cfg(1'b1, 1'b1, 1'b1);
        run_cfg(1'b0, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic clock_gate_test();
        clear_bench();
        clk_gate = 1'b1; run = 1'b1;
        repeat (300) @(negedge clk);
        chk(rises == 0, "R1", "bclk rises while gated", rises, 0);
        chk(ack_cnt == 0 && !dma_req, "R1", "transfers while gated", ack_cnt, 0);
        run = 1'b0; clk_gate = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule